// File: doc/BRIEF.md
# Modified Miller Pause Encoder

This block is the transmit side of a reader that talks to a proximity card by briefly switching its carrier off. It runs on the carrier clock, accepts a whole frame as a parallel word of bits plus a bit count, and replays it as a gate signal that is high while the carrier must be paused. Each transmitted symbol lasts 128 carrier cycles. A symbol is one of three shapes. Shape X pauses from the middle of the bit. Shape Z pauses from the start of the bit. Shape Y has no pause.

The shape chosen for a logical 0 depends on context. A 0 that follows a 1 is sent as Y. A 0 that follows another 0, or that comes straight after the start of frame, is sent as Z. A 1 is always sent as X. The block adds the start-of-frame symbol and the two end-of-frame symbols. For standard frames it can insert an odd parity bit after every complete byte. A caller pulses `start` with the frame on the inputs, waits for `done`, and may then send the next frame.

Top module: `miller_pause_tx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pause_gate`, `busy` and `done` are all low.
- R2: A frame opens with a Z symbol. Every symbol lasts exactly 128 cycles. Z pauses from cycle 0 of its symbol, X pauses from cycle 64, and Y never pauses. The gate is only ever high while `busy` is high.
- R3: A data bit of 1 is sent as X. Data bits go out from `frame_bits[0]` upward.
- R4: A data bit of 0 is sent as Z if the previous transmitted bit was 0, and as Y if the previous transmitted bit was 1.
- R5: When the first data bit is 0, it is sent as Z, and so is every 0 in the unbroken run that it starts.
- R6: With `parity_en` high, a parity bit follows every complete group of 8 data bits. The parity bit makes the count of ones in the group plus the parity bit odd. It is coded by the same rules as a data bit. No parity bit follows a trailing partial group, and none is inserted when `parity_en` is low.
- R7: The frame closes with a logical 0, coded by rule R4 against the last bit sent, followed by one Y symbol.
- R8: `start` is accepted only when the block is idle and `frame_len` is between 1 and 64. `busy` rises on the next cycle. A `start` pulse while busy, or one with an out-of-range length, has no effect.
- R9: `done` is high for exactly one cycle. It rises in the cycle after the last cycle of the closing Y, which is the same cycle in which `busy` falls.
- R10: The pause length in cycles is taken from `pause_len` when a frame is accepted. Changing `pause_len` during a frame has no effect on that frame.
- R11: The pause length is capped at 64 cycles, which is half a bit. The gate is therefore never high for more than 64 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to send the frame on the inputs |
| frame_bits | input | 64 | Frame data, bit 0 sent first |
| frame_len | input | 7 | Number of data bits, valid range 1 to 64 |
| parity_en | input | 1 | Insert odd parity after each complete byte |
| pause_len | input | 7 | Pause length in carrier cycles, capped at 64 |
| pause_gate | output | 1 | High while the carrier must be paused |
| busy | output | 1 | High while a frame is being sent |
| done | output | 1 | One-cycle pulse when a frame has ended |

## Verification
An accepted `start` shows on the outputs one cycle later. In that cycle `busy` is high and the start-of-frame pause begins at symbol cycle 0. Symbol k then covers the 128 cycles that begin 1 + 128·k cycles after acceptance, and `done` follows one cycle after the last of those cycles. The bench has a behavioural model that builds the full symbol list when a frame is accepted. The model advances one step on each rising edge. On each falling edge the bench compares gate, busy and done against the model, so every expected value falls in exactly the cycle in which the registered design state produces it.

// File: rtl/miller_pkg.sv
// Package: shared symbol and phase types for the pause encoder, plus the
// context rule that maps a logical bit onto a pause shape.
// Assumes: callers track whether the last transmitted bit was a zero.
package miller_pkg;

    typedef enum logic [1:0] {
        SYM_Y = 2'd0,
        SYM_X = 2'd1,
        SYM_Z = 2'd2
    } sym_t;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_SOF  = 3'd1,
        PH_DATA = 3'd2,
        PH_PAR  = 3'd3,
        PH_EOF0 = 3'd4,
        PH_EOF1 = 3'd5
    } phase_t;

    // One -> X; zero -> Z after a zero (or the start symbol), else Y.
    function automatic sym_t encode_bit(input logic bit_v, input logic prev_zero);
        if (bit_v)
            return SYM_X;
        else if (prev_zero)
            return SYM_Z;
        else
            return SYM_Y;
    endfunction

endpackage

// File: rtl/miller_bit_timer.sv
// Module: counts carrier cycles inside the current symbol and flags the last
// cycle of each symbol.
// Assumes: load is only raised while run is low (frame acceptance when idle).
module miller_bit_timer #(
    parameter int BIT_CYC = 128,
    localparam int CYC_W  = $clog2(BIT_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    output logic [CYC_W-1:0] cyc,
    output logic             sym_end
);

    localparam logic [CYC_W-1:0] LAST = CYC_W'(BIT_CYC - 1);

    // Cycle position inside the symbol, cleared on a new frame, wraps per symbol.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc <= '0;
        else if (load)
            cyc <= '0;
        else if (run)
            cyc <= (cyc == LAST) ? '0 : cyc + CYC_W'(1);
    end

    // Last cycle of the symbol being sent.
    always_comb sym_end = run && (cyc == LAST);

    // R2: a symbol ends exactly BIT_CYC-1 cycles after the previous one wrapped
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_end && !load) |=> (cyc == '0));

endmodule

// File: rtl/miller_frame_seq.sv
// Module: walks through start symbol, data bits, optional parity bits and the
// two closing symbols, choosing each pause shape from the bit context.
// Assumes: sym_end comes from the symbol timer and is high for one cycle per
// symbol; frame inputs are only sampled in the accepting cycle.
module miller_frame_seq #(
    parameter int MAX_BITS = 64,
    localparam int LEN_W   = $clog2(MAX_BITS + 1),
    localparam int IDX_W   = $clog2(MAX_BITS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [MAX_BITS-1:0]     frame_bits,
    input  logic [LEN_W-1:0]        frame_len,
    input  logic                    parity_en,
    input  logic                    sym_end,
    output logic                    accept,
    output logic                    busy,
    output logic                    done,
    output miller_pkg::sym_t        sym
);

    import miller_pkg::*;

    phase_t                phase;
    logic [MAX_BITS-1:0]   bits_q;
    logic [LEN_W-1:0]      len_q;
    logic                  par_en_q;
    logic [IDX_W-1:0]      idx;
    logic                  acc;
    logic                  par_q;
    logic                  cur_bit;
    logic                  last_data;
    logic                  byte_full;
    logic                  acc_n;
    logic [IDX_W-1:0]      nidx;

    // A frame request is taken only when idle and the length is in range.
    always_comb accept = start && (phase == PH_IDLE) && (frame_len != '0)
                         && (32'(frame_len) <= MAX_BITS);

    // Decode of the current data position.
    always_comb begin
        cur_bit   = bits_q[idx];
        nidx      = idx + IDX_W'(1);
        last_data = ((LEN_W'(idx) + LEN_W'(1)) == len_q);
        byte_full = (idx[2:0] == 3'd7);
        acc_n     = acc ^ cur_bit;
    end

    always_comb busy = (phase != PH_IDLE);

    // Frame phase machine: latches the frame and steps one symbol per sym_end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bits_q   <= '0;
            len_q    <= '0;
            par_en_q <= 1'b0;
            idx      <= '0;
            acc      <= 1'b0;
            par_q    <= 1'b0;
            sym      <= SYM_Y;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                phase    <= PH_SOF;
                bits_q   <= frame_bits;
                len_q    <= frame_len;
                par_en_q <= parity_en;
                idx      <= '0;
                acc      <= 1'b0;
                sym      <= SYM_Z;
            end else if (sym_end) begin
                unique case (phase)
                    PH_SOF: begin
                        phase <= PH_DATA;
                        idx   <= '0;
                        sym   <= encode_bit(bits_q[0], 1'b1);
                    end
                    PH_DATA: begin
                        if (par_en_q && byte_full) begin
                            phase <= PH_PAR;
                            par_q <= ~acc_n;
                            acc   <= 1'b0;
                            sym   <= encode_bit(~acc_n, ~cur_bit);
                        end else if (!last_data) begin
                            idx <= nidx;
                            acc <= acc_n;
                            sym <= encode_bit(bits_q[nidx], ~cur_bit);
                        end else begin
                            phase <= PH_EOF0;
                            sym   <= encode_bit(1'b0, ~cur_bit);
                        end
                    end
                    PH_PAR: begin
                        if (!last_data) begin
                            phase <= PH_DATA;
                            idx   <= nidx;
                            sym   <= encode_bit(bits_q[nidx], ~par_q);
                        end else begin
                            phase <= PH_EOF0;
                            sym   <= encode_bit(1'b0, ~par_q);
                        end
                    end
                    PH_EOF0: begin
                        phase <= PH_EOF1;
                        sym   <= SYM_Y;
                    end
                    PH_EOF1: begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R9: done is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done coincides with the fall of busy
    a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R7: the closing Y always follows the closing logical zero
    a_r7_eof_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EOF1) |-> (sym == SYM_Y));

endmodule

// File: rtl/miller_pause_shaper.sv
// Module: turns the current symbol shape and cycle position into the pause
// gate, using a pause width captured (and capped at half a bit) per frame.
// Assumes: load marks frame acceptance; run is high for the whole frame.
module miller_pause_shaper #(
    parameter int BIT_CYC = 128,
    parameter int PAUSE_W = 7,
    localparam int CYC_W  = $clog2(BIT_CYC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PAUSE_W-1:0] pause_len,
    input  logic               run,
    input  miller_pkg::sym_t   sym,
    input  logic [CYC_W-1:0]   cyc,
    output logic               gate
);

    import miller_pkg::*;

    localparam int HALF               = BIT_CYC / 2;
    localparam logic [CYC_W:0] HALF_V = (CYC_W + 1)'(HALF);

    logic [CYC_W:0] width_q;
    logic [CYC_W:0] cyc_x;
    logic           in_head;
    logic           in_mid;

    // Pause width for this frame, capped at half a bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            width_q <= '0;
        else if (load)
            width_q <= (32'(pause_len) > HALF) ? HALF_V : (CYC_W + 1)'(pause_len);
    end

    // Window tests for a pause at the start and at the middle of the bit.
    always_comb begin
        cyc_x   = {1'b0, cyc};
        in_head = (cyc_x < width_q);
        in_mid  = (cyc_x >= HALF_V) && (cyc_x < (HALF_V + width_q));
    end

    // Gate output from the symbol shape.
    always_comb begin
        gate = 1'b0;
        if (run) begin
            unique case (sym)
                SYM_Z:   gate = in_head;
                SYM_X:   gate = in_mid;
                default: gate = 1'b0;
            endcase
        end
    end

    // Checker support: length of the current high run of the gate.
    logic [CYC_W+1:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_run <= '0;
        else if (gate)
            hi_run <= hi_run + (CYC_W + 2)'(1);
        else
            hi_run <= '0;
    end

    // R11: no pause run exceeds half a bit
    a_r11_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
        32'(hi_run) <= HALF);

endmodule

// File: rtl/miller_pause_tx.sv
// Module: top of the pause encoder; joins the symbol timer, the frame
// sequencer and the pause shaper.
// Assumes: one carrier clock domain; frame inputs are stable in the start cycle.
module miller_pause_tx #(
    parameter int MAX_BITS = 64,
    parameter int BIT_CYC  = 128,
    parameter int PAUSE_W  = 7,
    localparam int LEN_W   = $clog2(MAX_BITS + 1),
    localparam int CYC_W   = $clog2(BIT_CYC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [MAX_BITS-1:0] frame_bits,
    input  logic [LEN_W-1:0]    frame_len,
    input  logic                parity_en,
    input  logic [PAUSE_W-1:0]  pause_len,
    output logic                pause_gate,
    output logic                busy,
    output logic                done
);

    import miller_pkg::*;

    logic             accept;
    logic             sym_end;
    logic [CYC_W-1:0] cyc;
    sym_t             sym;

    miller_bit_timer #(.BIT_CYC(BIT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .run     (busy),
        .cyc     (cyc),
        .sym_end (sym_end)
    );

    miller_frame_seq #(.MAX_BITS(MAX_BITS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_bits (frame_bits),
        .frame_len  (frame_len),
        .parity_en  (parity_en),
        .sym_end    (sym_end),
        .accept     (accept),
        .busy       (busy),
        .done       (done),
        .sym        (sym)
    );

    miller_pause_shaper #(.BIT_CYC(BIT_CYC), .PAUSE_W(PAUSE_W)) u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .pause_len (pause_len),
        .run       (busy),
        .sym       (sym),
        .cyc       (cyc),
        .gate      (pause_gate)
    );

    // R2: the gate is confined to frames
    a_r2_gate_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        pause_gate |-> busy);

    // R8: busy only rises after a start request
    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R2: every frame opens with a pause at its first cycle
    a_r2_sof_pause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> pause_gate || (cyc == '0));

endmodule

// File: tb/miller_pause_tx_bench.sv
`timescale 1ns/1ps
module miller_pause_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] frame_bits = '0;
    logic [6:0]  frame_len = '0;
    logic        parity_en = 1'b0;
    logic [6:0]  pause_len = 7'd28;
    logic        pause_gate;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    miller_pause_tx u_miller_pause_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_bits (frame_bits),
        .frame_len  (frame_len),
        .parity_en  (parity_en),
        .pause_len  (pause_len),
        .pause_gate (pause_gate),
        .busy       (busy),
        .done       (done)
    );

    // Reference model state: 0=Y 1=X 2=Z, tag = requirement number
    int q_sym[$];
    int q_tag[$];
    int t = 0;
    int w = 0;
    bit m_busy = 0;
    bit m_done = 0;

    function automatic int enc(int b, int prevz);
        if (b != 0) return 1;
        return (prevz != 0) ? 2 : 0;
    endfunction

    function automatic void build(logic [63:0] d, int len, bit par);
        int prevz;
        int ones;
        int p;
        q_sym = {};
        q_tag = {};
        q_sym.push_back(2); q_tag.push_back(2);
        prevz = 1;
        ones  = 0;
        for (int i = 0; i < len; i++) begin
            q_sym.push_back(enc(int'(d[i]), prevz));
            q_tag.push_back(d[i] ? 3 : ((prevz != 0 && i == 0) ? 5 : 4));
            prevz = d[i] ? 0 : 1;
            ones += int'(d[i]);
            if (par && (i % 8 == 7)) begin
                p = (ones % 2 == 0) ? 1 : 0;
                q_sym.push_back(enc(p, prevz));
                q_tag.push_back(6);
                prevz = (p == 0) ? 1 : 0;
                ones = 0;
            end
        end
        q_sym.push_back(enc(0, prevz)); q_tag.push_back(7);
        q_sym.push_back(0);             q_tag.push_back(7);
    endfunction

    // Model steps once per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0;
            m_done = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                t++;
                if (t == q_sym.size() * 128) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (start && frame_len != 0 && frame_len <= 64) begin
                build(frame_bits, int'(frame_len), parity_en);
                w = (int'(pause_len) > 64) ? 64 : int'(pause_len);
                t = 0;
                m_busy = 1;
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare outputs on every falling edge
    always @(negedge clk) begin
        int s;
        int c;
        int eg;
        int tag;
        if (rst_n) begin
            eg  = 0;
            tag = 2;
            if (m_busy) begin
                s   = t / 128;
                c   = t % 128;
                tag = q_tag[s];
                if (q_sym[s] == 2) eg = (c < w) ? 1 : 0;
                else if (q_sym[s] == 1) eg = (c >= 64 && c < 64 + w) ? 1 : 0;
            end
            chk(pause_gate == eg[0], $sformatf("R%0d gate", tag), int'(pause_gate), eg);
            chk(busy == m_busy, "R8 busy", int'(busy), int'(m_busy));
            chk(done == m_done, "R9 done", int'(done), int'(m_done));
        end
    end

    task automatic send(logic [63:0] d, int len, bit par, int pl);
        @(negedge clk);
        frame_bits = d;
        frame_len  = 7'(len);
        parity_en  = par;
        pause_len  = 7'(pl);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs low while in reset
        chk(!pause_gate && !busy && !done, "R1 in reset", int'({pause_gate, busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pause_gate && !busy && !done, "R1 after reset", int'({pause_gate, busy, done}), 0);

        // R2 R3 R4 R7: short frames with no parity
        send(64'h26, 7, 1'b0, 28);
        send(64'h52, 7, 1'b0, 28);
        // R5: first run of zeros all Z, with parity R6 on full bytes
        send(64'h0000, 16, 1'b1, 28);
        send(64'hFF, 8, 1'b1, 28);
        // R6: trailing partial byte gets no parity
        send(64'h0A55, 12, 1'b1, 21);
        send(64'h1, 1, 1'b0, 28);
        send(64'hF0E1_D2C3_B4A5_9687, 64, 1'b1, 30);

        // R8: zero and oversize lengths are ignored
        @(negedge clk);
        frame_len = 7'd0; start = 1'b1;
        @(negedge clk);
        frame_len = 7'd65;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(!busy, "R8 bad length ignored", int'(busy), 0);

        // R8 R10: start and pause_len changes while busy are ignored
        @(negedge clk);
        frame_bits = 64'hC3; frame_len = 7'd8; parity_en = 1'b0; pause_len = 7'd28;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        frame_bits = 64'h3C; frame_len = 7'd5; pause_len = 7'd50; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        repeat (3) @(negedge clk);

        // R11: width caps at half a bit
        send(64'h1B, 8, 1'b0, 100);
        send(64'h0B, 5, 1'b1, 64);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule